// File: doc/BRIEF.md
# Exception Status and Cause Unit

This block holds the three control registers a processor needs to take and leave exceptions: a status word (interrupt mask, user-mode flag, exception level, global interrupt enable), a cause word (pending interrupt lines, exception code, delay-slot flag) and a saved return address. A controller reports a synchronous fault as a valid pulse with a 5-bit code and the address of the faulting instruction. Six hardware request lines feed latched pending bits. Each cycle the unit decides whether an exception is taken and, if so, supplies a fixed handler address. The controller reads and writes the registers by register number, and it asks for an exception return, which yields the saved address as the next fetch address.

The exception level is the state of a two-state machine. `ST_OPEN` (level 0) accepts interrupts. `ST_HANDLER` (level 1) blocks them and is the reset state. The transitions are as follows. `T_ENTER` (ST_OPEN to ST_HANDLER) fires when an exception is taken. `T_NEST` (ST_HANDLER to itself) fires when a trap arrives during a handler. `T_RETURN` (ST_HANDLER to ST_OPEN) fires on a return request. `T_SW_SET` and `T_SW_CLEAR` fire when a status write sets or clears the level bit. Where several apply, a taken exception wins over a return, and a return wins over a register write.

Codes used: 0 is an external interrupt. Fault codes are supplied by the requester, for example 4 and 5 for load and store address errors, 6 and 7 for fetch and data bus errors, 8 syscall, 9 breakpoint, 10 reserved instruction and 12 overflow. Hardware line k sets cause bit 10+k. The receive line is line 1 (cause bit 11) and the transmit line is line 0 (cause bit 10).

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, register 12 (status) reads 0x00000002 (exception level 1, enable 0), register 13 (cause) reads 0 and register 14 (return address) reads 0.
- R2: Cause bit 10+k equals hw_irq[k] as sampled at the previous clock edge, whatever the mask, the enable or the exception level. Writes to those bits have no effect.
- R3: A write to register 13 stores only bits 9:8 (the software pending bits). All other written cause bits are ignored.
- R4: A write to register 12 stores bits 15:8 (mask), bit 4 (user mode), bit 1 (exception level) and bit 0 (enable). All other status bits read 0.
- R5: When no trap is presented, exc_take is 1 in the same cycle exactly when enable=1, exception level=0 and (cause[15:8] AND status[15:8]) is nonzero.
- R6: trap_valid=1 makes exc_take=1 in the same cycle regardless of enable, mask or exception level. A trap takes priority over a pending interrupt.
- R7: In the cycle after exc_take=1: the exception level is 1; cause[6:2] holds trap_code for a trap and 0 for an interrupt; cause[31] holds in_delay_slot; register 14 holds trap_pc for a trap and next_pc for an interrupt. exc_vector is always 0x80000180.
- R8: eret_pc always equals register 14. When eret_req=1 and no exception is taken, the exception level is 0 in the next cycle, and the mask, the enable and the user-mode bit are unchanged.
- R9: A register write presented in the same cycle as a taken exception or a return request is dropped.
- R10: Register numbers other than 12, 13 and 14 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | 6 | Hardware interrupt request lines |
| trap_valid | input | 1 | Synchronous fault reported this cycle |
| trap_code | input | 5 | Code of the reported fault |
| trap_pc | input | 32 | Address of the faulting instruction |
| next_pc | input | 32 | Address of the next instruction (saved for interrupts) |
| in_delay_slot | input | 1 | Excepting instruction sits in a branch delay slot |
| eret_req | input | 1 | Exception return request |
| reg_num | input | 5 | Register number for read and write |
| reg_wr_en | input | 1 | Write reg_wdata to register reg_num |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of register reg_num |
| exc_take | output | 1 | An exception is taken this cycle |
| exc_vector | output | 32 | Handler address |
| eret_pc | output | 32 | Return address for an exception return |

## Verification
A wrong exception level or a stale pending bit shows at exc_take in the very next cycle that an unmasked line is high, as a taken or a missed interrupt. A wrongly recorded code, delay flag or return address shows one cycle after a take, on reads of registers 13 and 14 and on eret_pc. The bench runs directed sequences for nesting, returns and same-cycle conflicts, then a long random mix. On every cycle it compares exc_take, exc_vector, eret_pc and reg_rdata against its own model, so a divergence is reported in the cycle it first appears.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int REG_NUM_W  = 5;
    localparam int REG_STATUS = 12;
    localparam int REG_CAUSE  = 13;
    localparam int REG_EPC    = 14;

    localparam int ST_EXL_BIT  = 1;
    localparam int ST_IE_BIT   = 0;
    localparam int ST_UM_BIT   = 4;
    localparam int MASK_LO     = 8;
    localparam int CA_CODE_LO  = 2;
    localparam int CA_BD_BIT   = 31;
    localparam int CODE_EXTINT = 0;

    typedef enum logic {
        ST_OPEN    = 1'b0,
        ST_HANDLER = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/exc_level_fsm.sv
module exc_level_fsm
    import exc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LEVELS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              eret,
    input  logic              st_wr,
    input  logic [XLEN-1:0]   st_wdata,
    output logic              exl,
    output logic              ie,
    output logic              user,
    output logic [LEVELS-1:0] mask
);
    lvl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HANDLER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (take)                                 state_d = ST_HANDLER;
                else if (st_wr && st_wdata[ST_EXL_BIT])   state_d = ST_HANDLER;
            end
            ST_HANDLER: begin
                if (take)                                 state_d = ST_HANDLER;
                else if (eret)                            state_d = ST_OPEN;
                else if (st_wr && !st_wdata[ST_EXL_BIT])  state_d = ST_OPEN;
            end
            default: state_d = ST_HANDLER;
        endcase
    end

    always_comb begin
        exl = (state_q == ST_HANDLER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            user <= 1'b0;
            mask <= '0;
        end else if (st_wr) begin
            ie   <= st_wdata[ST_IE_BIT];
            user <= st_wdata[ST_UM_BIT];
            mask <= st_wdata[MASK_LO +: LEVELS];
        end
    end

    p_eret_leaves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !take) |=> (state_q == ST_OPEN));

    p_eret_keeps_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !take) |=> (ie == $past(ie) && mask == $past(mask)));
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
    import exc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int HW_LINES = 6,
    parameter int SW_LINES = 2,
    parameter int CODE_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HW_LINES-1:0] hw_irq,
    input  logic                take,
    input  logic                is_trap,
    input  logic [CODE_W-1:0]   trap_code,
    input  logic                bd_in,
    input  logic                ca_wr,
    input  logic [XLEN-1:0]     ca_wdata,
    output logic [HW_LINES+SW_LINES-1:0] pend,
    output logic [CODE_W-1:0]   code,
    output logic                bd
);
    logic [HW_LINES-1:0] pend_hw_q;
    logic [SW_LINES-1:0] pend_sw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_hw_q <= '0;
        else        pend_hw_q <= hw_irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_sw_q <= '0;
        else if (ca_wr) pend_sw_q <= ca_wdata[MASK_LO +: SW_LINES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            bd   <= 1'b0;
        end else if (take) begin
            code <= is_trap ? trap_code : CODE_W'(CODE_EXTINT);
            bd   <= bd_in;
        end
    end

    assign pend = {pend_hw_q, pend_sw_q};

    p_code_zero_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_trap) |=> (code == '0));
endmodule

// File: rtl/exc_epc_reg.sv
module exc_epc_reg #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            is_trap,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic            epc_wr,
    input  logic [XLEN-1:0] epc_wdata,
    output logic [XLEN-1:0] epc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      epc <= '0;
        else if (take)   epc <= is_trap ? trap_pc : next_pc;
        else if (epc_wr) epc <= epc_wdata;
    end

    p_epc_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !is_trap) |=> (epc == $past(next_pc)));
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          HW_LINES = 6,
    parameter int          SW_LINES = 2,
    parameter int          CODE_W   = 5,
    parameter logic [31:0] VECTOR   = 32'h8000_0180
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HW_LINES-1:0]  hw_irq,
    input  logic                 trap_valid,
    input  logic [CODE_W-1:0]    trap_code,
    input  logic [XLEN-1:0]      trap_pc,
    input  logic [XLEN-1:0]      next_pc,
    input  logic                 in_delay_slot,
    input  logic                 eret_req,
    input  logic [REG_NUM_W-1:0] reg_num,
    input  logic                 reg_wr_en,
    input  logic [XLEN-1:0]      reg_wdata,
    output logic [XLEN-1:0]      reg_rdata,
    output logic                 exc_take,
    output logic [XLEN-1:0]      exc_vector,
    output logic [XLEN-1:0]      eret_pc
);
    localparam int LEVELS = HW_LINES + SW_LINES;
    localparam int BD_PAD = CA_BD_BIT - (MASK_LO + LEVELS);

    logic              exl_w, ie_w, user_w;
    logic [LEVELS-1:0] mask_w, pend_w;
    logic [CODE_W-1:0] code_w;
    logic              bd_w;
    logic [XLEN-1:0]   epc_w;
    logic              irq_hit, wr_ok;
    logic              wr_status, wr_cause, wr_epc;
    logic [XLEN-1:0]   status_word, cause_word;

    assign irq_hit  = ie_w && !exl_w && ((pend_w & mask_w) != '0);
    assign exc_take = trap_valid || irq_hit;
    assign wr_ok    = reg_wr_en && !exc_take && !eret_req;

    assign wr_status = wr_ok && (reg_num == REG_NUM_W'(REG_STATUS));
    assign wr_cause  = wr_ok && (reg_num == REG_NUM_W'(REG_CAUSE));
    assign wr_epc    = wr_ok && (reg_num == REG_NUM_W'(REG_EPC));

    exc_level_fsm #(.XLEN(XLEN), .LEVELS(LEVELS)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (exc_take),
        .eret     (eret_req),
        .st_wr    (wr_status),
        .st_wdata (reg_wdata),
        .exl      (exl_w),
        .ie       (ie_w),
        .user     (user_w),
        .mask     (mask_w)
    );

    exc_cause_reg #(.XLEN(XLEN), .HW_LINES(HW_LINES), .SW_LINES(SW_LINES), .CODE_W(CODE_W)) u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_irq    (hw_irq),
        .take      (exc_take),
        .is_trap   (trap_valid),
        .trap_code (trap_code),
        .bd_in     (in_delay_slot),
        .ca_wr     (wr_cause),
        .ca_wdata  (reg_wdata),
        .pend      (pend_w),
        .code      (code_w),
        .bd        (bd_w)
    );

    exc_epc_reg #(.XLEN(XLEN)) u_epc (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (exc_take),
        .is_trap   (trap_valid),
        .trap_pc   (trap_pc),
        .next_pc   (next_pc),
        .epc_wr    (wr_epc),
        .epc_wdata (reg_wdata),
        .epc       (epc_w)
    );

    always_comb begin
        status_word = '0;
        status_word[MASK_LO +: LEVELS] = mask_w;
        status_word[ST_UM_BIT]         = user_w;
        status_word[ST_EXL_BIT]        = exl_w;
        status_word[ST_IE_BIT]         = ie_w;
    end

    assign cause_word = {bd_w, {BD_PAD{1'b0}}, pend_w, 1'b0, code_w, 2'b00};

    always_comb begin
        unique case (reg_num)
            REG_NUM_W'(REG_STATUS): reg_rdata = status_word;
            REG_NUM_W'(REG_CAUSE):  reg_rdata = cause_word;
            REG_NUM_W'(REG_EPC):    reg_rdata = epc_w;
            default:                reg_rdata = '0;
        endcase
    end

    assign exc_vector = VECTOR;
    assign eret_pc    = epc_w;

    p_hw_pending_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_w[LEVELS-1:SW_LINES] == $past(hw_irq)));

    p_take_enters_handler_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> exl_w);

    p_epc_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take && trap_valid) |=> (epc_w == $past(trap_pc)));

    p_no_irq_in_handler_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exl_w && !trap_valid) |-> !exc_take);

    p_trap_always_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> exc_take);

    p_dropped_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && eret_req && !exc_take && reg_num == REG_NUM_W'(REG_EPC))
            |=> (epc_w == $past(epc_w)));
endmodule

// File: tb/exc_ctrl_unit_tb.sv
module exc_ctrl_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  hw_irq;
    logic        trap_valid;
    logic [4:0]  trap_code;
    logic [31:0] trap_pc, next_pc;
    logic        in_delay_slot, eret_req;
    logic [4:0]  reg_num;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata, exc_vector, eret_pc;
    logic        exc_take;

    int vectors = 0;
    int misses  = 0;
    string force_tag = "";

    logic [31:0] m_status, m_cause, m_epc;

    exc_ctrl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .trap_valid(trap_valid),
        .trap_code(trap_code), .trap_pc(trap_pc), .next_pc(next_pc),
        .in_delay_slot(in_delay_slot), .eret_req(eret_req), .reg_num(reg_num),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .exc_take(exc_take), .exc_vector(exc_vector), .eret_pc(eret_pc)
    );

    always #10 clk = ~clk;

    function automatic logic exp_take();
        logic irq;
        irq = m_status[0] && !m_status[1] && ((m_cause[15:8] & m_status[15:8]) != 8'h00);
        return trap_valid || irq;
    endfunction

    function automatic logic [31:0] exp_rdata();
        case (reg_num)
            5'd12:   return m_status;
            5'd13:   return m_cause;
            5'd14:   return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic model_step();
        logic tk;
        tk = exp_take();
        if (tk) begin
            m_status[1]   = 1'b1;
            m_cause[6:2]  = trap_valid ? trap_code : 5'd0;
            m_cause[31]   = in_delay_slot;
            m_epc         = trap_valid ? trap_pc : next_pc;
        end else if (eret_req) begin
            m_status[1] = 1'b0;
        end else if (reg_wr_en) begin
            case (reg_num)
                5'd12: m_status = reg_wdata & 32'h0000_FF13;
                5'd13: m_cause[9:8] = reg_wdata[9:8];
                5'd14: m_epc = reg_wdata;
                default: ;
            endcase
        end
        m_cause[15:10] = hw_irq;
    endtask

    task automatic cycle();
        string t_take, t_rd;
        #2;
        t_take = (force_tag != "") ? force_tag : (trap_valid ? "R6" : "R5");
        case (reg_num)
            5'd12:   t_rd = "R4";
            5'd13:   t_rd = "R2";
            5'd14:   t_rd = "R7";
            default: t_rd = "R10";
        endcase
        if (force_tag != "") t_rd = force_tag;
        check(t_take, "exc_take", {31'b0, exc_take}, {31'b0, exp_take()});
        check("R7", "exc_vector", exc_vector, 32'h8000_0180);
        check((force_tag != "") ? force_tag : "R8", "eret_pc", eret_pc, m_epc);
        check(t_rd, "reg_rdata", reg_rdata, exp_rdata());
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        trap_valid = 0; eret_req = 0; reg_wr_en = 0; in_delay_slot = 0;
    endtask

    task automatic wr(input logic [4:0] n, input logic [31:0] d);
        idle(); reg_num = n; reg_wr_en = 1; reg_wdata = d; cycle(); reg_wr_en = 0;
    endtask

    task automatic rd(input logic [4:0] n);
        idle(); reg_num = n; cycle();
    endtask

    initial begin
        #(20 * 150000);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst_n = 0; hw_irq = 0; trap_code = 0; trap_pc = 0; next_pc = 32'h0040_0000;
        reg_num = 0; reg_wdata = 0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_status = 32'h2; m_cause = 0; m_epc = 0;

        force_tag = "R1";
        rd(12); rd(13); rd(14);
        force_tag = "R10";
        wr(7, 32'hFFFF_FFFF); rd(7); rd(12); rd(13); rd(14);
        force_tag = "R4";
        wr(12, 32'hFFFF_FFFF); rd(12);
        wr(12, 32'h0000_0011); rd(12);
        force_tag = "R2";
        hw_irq = 6'b000010; rd(13); rd(13);
        wr(13, 32'h0000_0000); rd(13);
        force_tag = "R5";
        next_pc = 32'h0040_0010;
        wr(12, 32'h0000_0811); rd(13); rd(14); rd(12);
        force_tag = "R8";
        idle(); hw_irq = 0; eret_req = 1; reg_num = 14; cycle(); rd(12);
        force_tag = "R3";
        wr(13, 32'hFFFF_FFFF); rd(13);
        wr(12, 32'h0000_0111); rd(13); rd(12);
        wr(13, 32'h0); rd(13);
        force_tag = "R9";
        idle(); eret_req = 1; reg_num = 12; reg_wr_en = 1; reg_wdata = 32'h0; cycle(); rd(12);
        force_tag = "R6";
        idle(); trap_valid = 1; trap_code = 5'd12; trap_pc = 32'h0040_0100; in_delay_slot = 1;
        reg_num = 13; cycle(); rd(13); rd(14); rd(12);
        idle(); trap_valid = 1; trap_code = 5'd8; trap_pc = 32'h0040_0200;
        reg_wr_en = 1; reg_num = 14; reg_wdata = 32'hDEAD_BEEF; cycle(); rd(13); rd(14);
        force_tag = "R8";
        idle(); eret_req = 1; reg_num = 12; cycle(); rd(12); rd(14);

        force_tag = "";
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] pick [4];
            pick[0] = 12; pick[1] = 13; pick[2] = 14; pick[3] = 5'($urandom_range(0, 31));
            idle();
            if ($urandom_range(0, 7) == 0) hw_irq = 6'($urandom);
            trap_valid    = ($urandom_range(0, 15) == 0);
            trap_code     = 5'($urandom);
            trap_pc       = $urandom;
            next_pc       = $urandom;
            in_delay_slot = 1'($urandom);
            eret_req      = ($urandom_range(0, 11) == 0);
            reg_wr_en     = ($urandom_range(0, 5) == 0);
            reg_num       = pick[$urandom_range(0, 3)];
            reg_wdata     = $urandom;
            cycle();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule